// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host sends each code over three wires: an active-low select, a serial clock and a data line. All of these inputs are brought into one system clock domain. Inside that domain the block shifts data bits into an input register and counts the serial clock edges in each frame. The block is double-buffered. Only a frame of exactly the expected length may be copied into the converter latch. The latch drives the code that the analog side sees.

An active-low load input chooses when a good frame is applied. If the load input is low when select rises, the word is applied at once. This is the three-wire use, with the load input tied low. If the load input is high when select rises, the word is held. It is applied on the next falling edge of the load input that arrives while select is high. This is the four-wire use. Frames of the wrong length are dropped, and the block reports them with a one-cycle error pulse. The serial clock must run at no more than a quarter of the system clock.

Top module: `sdac_frontend`

## Requirements
- R1: During and straight after reset, `dac_code` is 0x0000 and neither `upd_stb` nor `frame_err` pulses.
- R2: Bits are taken from `sdi_in` on rising edges of `sck_in` while `cs_n_in` is low. The first bit becomes bit 15 of the code and the last becomes bit 0.
- R3: When a frame of exactly 16 edges ends (rising `cs_n_in`) with `ld_n_in` low, the latch takes the shifted word without further action.
- R4: When a 16-edge frame ends with `ld_n_in` high, the latch keeps its old code. It takes the new word on the next falling edge of `ld_n_in` that occurs while `cs_n_in` is high.
- R5: A falling edge of `ld_n_in` while `cs_n_in` is low does not change the latch.
- R6: A frame that ends after any edge count other than 16 leaves the latch unchanged and pulses `frame_err` for exactly one system clock. It also discards any word still waiting for a load edge.
- R7: `upd_stb` is high for exactly one cycle for each latch change, and `dac_code` does not change in any other cycle.
- R8: Serial clock edges while `cs_n_in` is high are neither shifted in nor counted.
- R9: A good frame that follows a bad frame loads normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous active-low frame select |
| sck_in | input | 1 | Asynchronous serial clock, idles low |
| sdi_in | input | 1 | Asynchronous serial data, MSB first |
| ld_n_in | input | 1 | Asynchronous active-low latch load |
| dac_code | output | 16 | Code presented to the converter |
| upd_stb | output | 1 | One-cycle pulse when `dac_code` changes |
| frame_err | output | 1 | One-cycle pulse when a frame of bad length is dropped |

## Verification
The hardest case to reach is a four-wire word that is still waiting when a corrupt frame arrives. A later load edge must then do nothing. The stimulus first leaves a good word pending with the load input high. It then sends a 15-edge frame and pulses the load input. Finally it checks that there is no update and that the code has not moved. A load pulse in the middle of a frame, and serial clocks while select is idle, are also driven so that ignored events can be seen at the outputs.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int unsigned SDAC_WORD_W = 16;
    localparam int unsigned SDAC_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_APPLY = 2'd1,
        END_HOLD  = 2'd2,
        END_BAD   = 2'd3
    } frame_end_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef logic [WIDTH-1:0] vec_t;
    vec_t [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W = SDAC_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              ld_s,
    output logic              load_o,
    output logic [WORD_W-1:0] word_o,
    output logic              err_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic              ld_prev;
        logic              active;
        logic              pending;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              err;
    } frm_t;

    frm_t st_d, st_q;
    frame_end_e end_kind;
    logic cs_fall, cs_rise, sck_rise, ld_fall, load_c;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        load_c   = 1'b0;
        end_kind = END_NONE;
        cs_fall  = st_q.cs_prev & ~cs_s;
        cs_rise  = ~st_q.cs_prev & cs_s;
        sck_rise = ~st_q.sck_prev & sck_s;
        ld_fall  = st_q.ld_prev & ~ld_s;
        st_d.cs_prev  = cs_s;
        st_d.sck_prev = sck_s;
        st_d.ld_prev  = ld_s;

        if (cs_rise && st_q.active) begin
            if (st_q.cnt != CNT_FULL) end_kind = END_BAD;
            else if (!ld_s)           end_kind = END_APPLY;
            else                      end_kind = END_HOLD;
        end

        if (cs_fall) begin
            st_d.active  = 1'b1;
            st_d.pending = 1'b0;
            st_d.cnt     = '0;
        end else if (cs_rise) begin
            st_d.active = 1'b0;
            unique case (end_kind)
                END_APPLY: load_c = 1'b1;
                END_HOLD:  st_d.pending = 1'b1;
                END_BAD:   st_d.err = 1'b1;
                default:   ;
            endcase
        end else if (!cs_s && st_q.active && sck_rise) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdi_s};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end else if (cs_s && ld_fall && st_q.pending) begin
            load_c       = 1'b1;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_prev  <= 1'b1;
            st_q.ld_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = load_c;
    assign word_o = st_q.shreg;
    assign err_o  = st_q.err;
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
    parameter int unsigned WORD_W = 16,
    parameter logic [WORD_W-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] code_o,
    output logic              upd_o
);
    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic              upd;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d     = lat_q;
        lat_d.upd = load_i;
        if (load_i) lat_d.code = word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q.code <= RST_CODE;
            lat_q.upd  <= 1'b0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign code_o = lat_q.code;
    assign upd_o  = lat_q.upd;
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W = SDAC_WORD_W,
    parameter int unsigned SYNC_STAGES = SDAC_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    input  logic              ld_n_in,
    output logic [WORD_W-1:0] dac_code,
    output logic              upd_stb,
    output logic              frame_err
);
    localparam int unsigned NUM_IN = 4;
    localparam logic [NUM_IN-1:0] IN_IDLE = 4'b1001;

    logic [NUM_IN-1:0] raw_in, syn_in;
    logic              load_w;
    logic [WORD_W-1:0] word_w;

    assign raw_in = {cs_n_in, sck_in, sdi_in, ld_n_in};

    sdac_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_IDLE)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (syn_in)
    );

    sdac_framer #(.WORD_W(WORD_W)) framer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (syn_in[3]),
        .sck_s (syn_in[2]),
        .sdi_s (syn_in[1]),
        .ld_s  (syn_in[0]),
        .load_o(load_w),
        .word_o(word_w),
        .err_o (frame_err)
    );

    sdac_latch #(.WORD_W(WORD_W), .RST_CODE('0)) latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_w),
        .word_i(word_w),
        .code_o(dac_code),
        .upd_o (upd_stb)
    );
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] dac_code,
    input logic              upd_stb,
    input logic              frame_err
);
    // R7: code only moves in a strobe cycle
    a_r7_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> $stable(dac_code));

    // R7: strobe lasts one cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    // R6: error pulse lasts one cycle
    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6: a dropped frame never updates the latch
    a_r6_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_err, upd_stb}));
endmodule

bind sdac_frontend sdac_frontend_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_code (dac_code),
    .upd_stb  (upd_stb),
    .frame_err(frame_err)
);

// File: tb/sdac_frontend_tb_top.sv
module sdac_frontend_tb_top;
    localparam int W = 16;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, sdi, ld_n;
    logic [W-1:0] dac_code;
    logic upd_stb, frame_err;

    int checks = 0, fails = 0, upd_cnt = 0, err_cnt = 0, pushed = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    sdac_frontend #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sck_in(sck),
        .sdi_in(sdi), .ld_n_in(ld_n), .dac_code(dac_code),
        .upd_stb(upd_stb), .frame_err(frame_err)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_word(logic [W-1:0] w, string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
        pushed++;
    endtask

    // driver: one frame of nbits clocks, optional load pulse mid-frame
    task automatic send(logic [W-1:0] w, int nbits, bit push, string tag, bit mid_ld);
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < W) ? w[W-1-i] : 1'b0;
            if (mid_ld && i == 8) ld_n = 1'b0;
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
            if (mid_ld && i == 8) ld_n = 1'b1;
        end
        tick(HALF);
        if (push) expect_word(w, tag);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic ld_pulse(bit push, logic [W-1:0] w, string tag);
        if (push) expect_word(w, tag);
        ld_n = 1'b0;
        tick(HALF);
        ld_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        logic [W-1:0] w;
        string t;
        if (rst_n === 1'b1) begin
            if (upd_stb) begin
                upd_cnt++;
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7 unexpected update act=%h exp=none", dac_code);
                end else begin
                    w = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(dac_code == w, t, 32'(dac_code), 32'(w));
                end
            end
            if (frame_err) err_cnt++;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int u0, e0;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; ld_n = 1'b0;
        tick(4);
        check(dac_code == '0, "R1", 32'(dac_code), 32'h0);
        rst_n = 1'b1;
        tick(6);
        check(upd_cnt == 0 && err_cnt == 0, "R1", 32'(upd_cnt + err_cnt), 32'h0);

        // three-wire frames, bit order
        send(16'hA5C3, W, 1'b1, "R3", 1'b0);
        send(16'h8000, W, 1'b1, "R2", 1'b0);
        check(dac_code[W-1] == 1'b1, "R2", 32'(dac_code), 32'h8000);
        send(16'h0001, W, 1'b1, "R2", 1'b0);
        send(16'hFFFF, W, 1'b1, "R3", 1'b0);

        // four-wire: hold until load edge
        ld_n = 1'b1;
        tick(2 * HALF);
        send(16'h1234, W, 1'b0, "R4", 1'b0);
        check(dac_code == 16'hFFFF, "R4", 32'(dac_code), 32'hFFFF);
        ld_pulse(1'b1, 16'h1234, "R4");
        check(dac_code == 16'h1234, "R4", 32'(dac_code), 32'h1234);

        // load edge inside a frame is ignored
        u0 = upd_cnt;
        send(16'h5555, W, 1'b0, "R5", 1'b1);
        check(upd_cnt == u0, "R5", 32'(upd_cnt), 32'(u0));
        check(dac_code == 16'h1234, "R5", 32'(dac_code), 32'h1234);
        ld_pulse(1'b1, 16'h5555, "R4");

        // bad lengths in three-wire use
        ld_n = 1'b0;
        tick(2 * HALF);
        u0 = upd_cnt; e0 = err_cnt;
        send(16'h0F0F, W - 1, 1'b0, "R6", 1'b0);
        check(err_cnt == e0 + 1, "R6", 32'(err_cnt), 32'(e0 + 1));
        send(16'hF0F0, W + 1, 1'b0, "R6", 1'b0);
        check(err_cnt == e0 + 2, "R6", 32'(err_cnt), 32'(e0 + 2));
        check(upd_cnt == u0 && dac_code == 16'h5555, "R6", 32'(dac_code), 32'h5555);

        // pending word cancelled by a bad frame
        ld_n = 1'b1;
        tick(2 * HALF);
        send(16'h7777, W, 1'b0, "R6", 1'b0);
        send(16'h3333, W - 1, 1'b0, "R6", 1'b0);
        u0 = upd_cnt;
        ld_pulse(1'b0, '0, "R6");
        check(upd_cnt == u0 && dac_code == 16'h5555, "R6", 32'(dac_code), 32'h5555);

        // idle clocks, then good frame after error
        ld_n = 1'b0;
        tick(2 * HALF);
        for (int k = 0; k < 5; k++) begin
            sdi = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        send(16'hBEEF, W, 1'b1, "R8", 1'b0);
        check(dac_code == 16'hBEEF, "R9", 32'(dac_code), 32'hBEEF);
        send(16'h0000, W, 1'b1, "R3", 1'b0);

        tick(4 * HALF);
        check(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'h0);
        check(upd_cnt == pushed, "R7", 32'(upd_cnt), 32'(pushed));
        done = 1'b1;
        summary();
        $finish;
    end
endmodule